// File: doc/BRIEF.md
# Serial Audio Stereo Transmitter

This block turns a stream of signed audio samples into a single serial data line. A processor places the samples in a 16-entry queue through a simple write port. The block sends them in the standard two-channel format. A word-select line marks each half-frame: low means left, high means right. Each word begins one bit period after the word-select edge that opens its slot and goes out most significant bit first.

The bit clock and word select can come from two places. In master mode the block builds them from a bit-rate tick that an external divider supplies. In slave mode they come from pins that are already synchronous to the system clock. The transmitter fits each sample into a slot of 16, 24 or 32 bit times. If the slot is longer than the sample, the tail is filled with zeros. If the slot is shorter, the low bits are dropped. The block can raise one combined interrupt from three masked sources: the queue level falling to a programmable mark, a write into a full queue, and a word start that finds the queue empty. Clearing the global enable empties the queue and silences the serial outputs.

Top module: `serial_audio_tx`

## Requirements
- R1: Within each slot, the word's most significant bit is on `sdo` during the bit period that follows the word-select transition opening that slot. The remaining bits follow in descending order, and the sample's two's-complement bits are sent unchanged.
- R2: A word-select low slot carries a left word and a high slot carries a right word. Queue entries are sent in write order, and the first entry after enable goes into the first left slot.
- R3: `slotSel` = 0 gives 16, 1 gives 24, and 2 or 3 gives 32 bit periods per word-select half. In master mode, word select is low at enable, rises on the first falling bit-clock edge, and then changes only on falling bit-clock edges, once per slot.
- R4: When the slot is longer than `SAMPLE_W`, the bit times after the sample's LSB carry zero.
- R5: When the slot is shorter than `SAMPLE_W`, only the top slot-length bits of the sample are sent.
- R6: With `launchOnRise` = 0, `sdo` changes only after falling bit-clock edges. With `launchOnRise` = 1, it changes only after rising edges. In both cases, R1's one-bit delay counts launch edges.
- R7: The queue holds 16 samples. A write while it is full is discarded and sets the overrun flag.
- R8: The threshold source is active while the block is enabled and the queue level is less than or equal to `trigLevel`.
- R9: The overrun and underrun flags are sticky. A one-cycle `statusRd` pulse clears both. A new event in the same cycle wins over the clear.
- R10: If the queue is empty when a word starts after the frame has begun, the word is sent as all zeros and the underrun flag is set.
- R11: `irq` is the OR of the sources ANDed with `intMask`: bit 0 is threshold, bit 1 is overrun, bit 2 is underrun.
- R12: The global enable is 0 after reset. While it is 0, the queue is emptied, the word in flight is lost, writes are ignored, and `sdo`, `sclkOut` and `wsOut` stay low.
- R13: With the global enable on and `txEn` off, no queue entry is consumed and `sdo` stays low.
- R14: After enable, slots before the first word-select high-to-low transition carry zeros. These slots consume nothing and do not flag underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| globalEn | input | 1 | Global enable; 0 flushes and silences |
| txEn | input | 1 | Transmitter enable, overridden by globalEn |
| masterMode | input | 1 | 1: generate bit clock and word select locally |
| launchOnRise | input | 1 | 1: launch data on rising bit-clock edges |
| slotSel | input | 2 | Slot length select (16/24/32) |
| bitTick | input | 1 | Half-bit-period tick from an external divider (master) |
| sclkIn | input | 1 | External bit clock (slave), synchronous |
| wsIn | input | 1 | External word select (slave), synchronous |
| wrEn | input | 1 | Queue write strobe |
| wrData | input | SAMPLE_W | Sample to queue |
| trigLevel | input | LVL_W | Threshold level for the empty-threshold source |
| intMask | input | 3 | Per-source interrupt enables |
| statusRd | input | 1 | Status read pulse, clears sticky flags |
| sdo | output | 1 | Serial data out |
| sclkOut | output | 1 | Generated bit clock (low in slave mode) |
| wsOut | output | 1 | Generated word select (low in slave mode) |
| overrun | output | 1 | Sticky overrun flag |
| underrun | output | 1 | Sticky underrun flag |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench keeps the defaults: a 24-bit sample and a 16-entry queue. With a 24-bit sample, a single build covers an exact fit in the 24-bit slot, truncation in the 16-bit slot and zero padding in the 32-bit slot. A queue depth of 16 lets the bench drive the level to the full boundary with a few directed writes and the threshold to both extremes. Master mode is used throughout, so generated word-select timing and both launch edges are checked against the recorded serial stream.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  localparam int SLOT_MAX = 32;
  localparam int SLOT_CNT_W = 6;

  // control to datapath strobes, one cycle wide
  typedef struct packed {
    logic launch;    // a launch edge of the bit clock was seen
    logic load;      // word-select changed at this launch edge
    logic takeFifo;  // the new word comes from the queue head
    logic flush;     // transmitter idle: clear shifter and output
  } txStrobe_t;

  function automatic logic [SLOT_CNT_W-1:0] slotLen(input logic [1:0] sel);
    case (sel)
      2'd0:    return SLOT_CNT_W'(16);
      2'd1:    return SLOT_CNT_W'(24);
      default: return SLOT_CNT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int DATA_W = 24,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic              doPush;
  logic              doPop;

  assign full   = (level == LVL_W'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  assign headData = store[rdPtr];

  // R7: level never passes the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  // R12: a flush leaves the queue empty
  a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);

endmodule

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             globalEn,
  input  logic             txEn,
  input  logic             masterMode,
  input  logic             launchOnRise,
  input  logic [1:0]       slotSel,
  input  logic             bitTick,
  input  logic             sclkIn,
  input  logic             wsIn,
  input  logic             wrEn,
  input  logic             statusRd,
  input  logic [LVL_W-1:0] trigLevel,
  input  logic [2:0]       intMask,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  input  logic [LVL_W-1:0] fifoLevel,
  output txStrobe_t        strobe,
  output logic             fifoPush,
  output logic             fifoPop,
  output logic             fifoFlush,
  output logic             sclkOut,
  output logic             wsOut,
  output logic             overrun,
  output logic             underrun,
  output logic             irq
);

  logic                  active;
  logic                  mSclk;
  logic                  mWs;
  logic                  mStarted;
  logic [SLOT_CNT_W-1:0] mCnt;
  logic [SLOT_CNT_W-1:0] slotBits;

  assign active   = globalEn & txEn;
  assign slotBits = slotLen(slotSel);

  // local bit clock and word select generator
  always_ff @(posedge clk) begin
    if (!rstN || !globalEn || !masterMode) begin
      mSclk    <= 1'b0;
      mWs      <= 1'b0;
      mStarted <= 1'b0;
      mCnt     <= '0;
    end else if (bitTick) begin
      mSclk <= ~mSclk;
      if (mSclk) begin
        if (!mStarted) begin
          mWs      <= 1'b1;
          mStarted <= 1'b1;
          mCnt     <= '0;
        end else if (mCnt == slotBits - SLOT_CNT_W'(1)) begin
          mWs  <= ~mWs;
          mCnt <= '0;
        end else begin
          mCnt <= mCnt + SLOT_CNT_W'(1);
        end
      end
    end
  end

  assign sclkOut = masterMode & mSclk;
  assign wsOut   = masterMode & mWs;

  // edge tracking on the selected timing source
  logic sclkSel;
  logic wsSel;
  logic sclkPrev;
  logic wsLast;
  logic armed;
  logic launch;
  logic wsChange;
  logic wordStart;
  logic starve;

  assign sclkSel = masterMode ? mSclk : sclkIn;
  assign wsSel   = masterMode ? mWs : wsIn;

  always_ff @(posedge clk) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkSel;
  end

  assign launch    = active & (launchOnRise ? (sclkSel & ~sclkPrev) : (~sclkSel & sclkPrev));
  assign wsChange  = launch & (wsSel != wsLast);
  assign wordStart = wsChange & (armed | ~wsSel);
  assign fifoPop   = wordStart & ~fifoEmpty;
  assign starve    = wordStart & fifoEmpty;

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      wsLast <= 1'b0;
      armed  <= 1'b0;
    end else if (launch) begin
      wsLast <= wsSel;
      if (wsChange && !wsSel) armed <= 1'b1;
    end
  end

  always_comb begin
    strobe.launch   = launch;
    strobe.load     = wsChange;
    strobe.takeFifo = fifoPop;
    strobe.flush    = ~active;
  end

  assign fifoPush  = wrEn & globalEn;
  assign fifoFlush = ~globalEn;

  // sticky status, set wins over clear
  logic overrunSet;
  assign overrunSet = wrEn & globalEn & fifoFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrun  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      overrun  <= overrunSet | (overrun & ~statusRd);
      underrun <= starve | (underrun & ~statusRd);
    end
  end

  logic threshSrc;
  assign threshSrc = globalEn & (fifoLevel <= trigLevel);
  assign irq = |({underrun, overrun, threshSrc} & intMask);

  // R12: generated timing is silent one cycle after disable
  a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> (!sclkOut && !wsOut));

  // R3: generated word select only moves on a falling bit clock
  a_r3_ws_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && globalEn && $past(masterMode) && $past(globalEn) && !$stable(wsOut))
      |-> $fell(sclkOut));

  // R7: a write into a full queue latches overrun
  a_r7_overrun_latch: assert property (@(posedge clk) disable iff (!rstN)
    overrunSet |=> overrun);

  // R10: an empty queue at an armed word start latches underrun
  a_r10_underrun_latch: assert property (@(posedge clk) disable iff (!rstN)
    starve |=> underrun);

endmodule

// File: rtl/audio_tx_datapath.sv
module audio_tx_datapath
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] fifoData,
  output logic                sdo
);

  localparam int PAD_W = SLOT_MAX - SAMPLE_W;

  logic [SLOT_MAX-1:0] shiftQ;
  logic [SLOT_MAX-1:0] loadWord;

  // left-align the sample in the widest slot
  generate
    if (PAD_W > 0) begin : g_pad
      assign loadWord = {fifoData, {PAD_W{1'b0}}};
    end else begin : g_trunc
      assign loadWord = fifoData[SAMPLE_W-1 -: SLOT_MAX];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      shiftQ <= '0;
      sdo    <= 1'b0;
    end else if (strobe.launch) begin
      sdo <= shiftQ[SLOT_MAX-1];
      if (strobe.load) shiftQ <= strobe.takeFifo ? loadWord : '0;
      else             shiftQ <= shiftQ << 1;
    end
  end

  // R6: the output only moves after a launch edge or a flush
  a_r6_sdo_moves_on_launch: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.launch) && !$past(strobe.flush)) |-> $stable(sdo));

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                globalEn,
  input  logic                txEn,
  input  logic                masterMode,
  input  logic                launchOnRise,
  input  logic [1:0]          slotSel,
  input  logic                bitTick,
  input  logic                sclkIn,
  input  logic                wsIn,
  input  logic                wrEn,
  input  logic [SAMPLE_W-1:0] wrData,
  input  logic [LVL_W-1:0]    trigLevel,
  input  logic [2:0]          intMask,
  input  logic                statusRd,
  output logic                sdo,
  output logic                sclkOut,
  output logic                wsOut,
  output logic                overrun,
  output logic                underrun,
  output logic                irq
);

  txStrobe_t           strobe;
  logic                fifoPush;
  logic                fifoPop;
  logic                fifoFlush;
  logic                fifoFull;
  logic                fifoEmpty;
  logic [LVL_W-1:0]    fifoLevel;
  logic [SAMPLE_W-1:0] headData;

  audio_tx_fifo #(.DATA_W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN), .flush(fifoFlush), .push(fifoPush), .pushData(wrData),
    .pop(fifoPop), .headData(headData), .level(fifoLevel), .full(fifoFull), .empty(fifoEmpty)
  );

  audio_tx_ctrl #(.LVL_W(LVL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .txEn(txEn), .masterMode(masterMode),
    .launchOnRise(launchOnRise), .slotSel(slotSel), .bitTick(bitTick), .sclkIn(sclkIn),
    .wsIn(wsIn), .wrEn(wrEn), .statusRd(statusRd), .trigLevel(trigLevel), .intMask(intMask),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fifoLevel(fifoLevel), .strobe(strobe),
    .fifoPush(fifoPush), .fifoPop(fifoPop), .fifoFlush(fifoFlush), .sclkOut(sclkOut),
    .wsOut(wsOut), .overrun(overrun), .underrun(underrun), .irq(irq)
  );

  audio_tx_datapath #(.SAMPLE_W(SAMPLE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fifoData(headData), .sdo(sdo)
  );

endmodule

// File: tb/serial_audio_tx_tb_top.sv
module serial_audio_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE_W = 24;
  localparam int FIFO_DEPTH = 16;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalEn = 1'b0, txEn = 1'b0, masterMode = 1'b1, launchOnRise = 1'b0;
  logic [1:0] slotSel = 2'd0;
  logic bitTick = 1'b0, sclkIn = 1'b0, wsIn = 1'b0, wrEn = 1'b0, statusRd = 1'b0;
  logic [SAMPLE_W-1:0] wrData = '0;
  logic [LVL_W-1:0] trigLevel = '0;
  logic [2:0] intMask = 3'b000;
  logic sdo, sclkOut, wsOut, overrun, underrun, irq;

  serial_audio_tx #(.SAMPLE_W(SAMPLE_W), .FIFO_DEPTH(FIFO_DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .txEn(txEn), .masterMode(masterMode),
    .launchOnRise(launchOnRise), .slotSel(slotSel), .bitTick(bitTick), .sclkIn(sclkIn),
    .wsIn(wsIn), .wrEn(wrEn), .wrData(wrData), .trigLevel(trigLevel), .intMask(intMask),
    .statusRd(statusRd), .sdo(sdo), .sclkOut(sclkOut), .wsOut(wsOut), .overrun(overrun),
    .underrun(underrun), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [1:0]  sel;
    logic [23:0] smp;
    logic [31:0] exp;
  } vec_t;

  // four samples per slot length: 24 exact, 16 truncated, 32 padded
  localparam vec_t VEC [12] = '{
    '{2'd1, 24'h800001, 32'h80000100}, '{2'd1, 24'h7FFFFE, 32'h7FFFFE00},
    '{2'd1, 24'h123456, 32'h12345600}, '{2'd1, 24'hFEDCBA, 32'hFEDCBA00},
    '{2'd0, 24'hABCDEF, 32'hABCD0000}, '{2'd0, 24'h00FF00, 32'h00FF0000},
    '{2'd0, 24'h8000FF, 32'h80000000}, '{2'd0, 24'h13579B, 32'h13570000},
    '{2'd2, 24'hC0FFEE, 32'hC0FFEE00}, '{2'd2, 24'h000001, 32'h00000100},
    '{2'd2, 24'h5A5A5A, 32'h5A5A5A00}, '{2'd2, 24'hFFFFFF, 32'hFFFFFF00}
  };

  int checks = 0;
  int failures = 0;
  logic recSdo [512];
  logic recWs [512];
  logic [31:0] expW [8];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeWord(input logic [SAMPLE_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseRead();
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  // runs the tick source and records sdo/ws at chosen bit-clock edges
  task automatic stream(input int nRec, input bit onRise);
    int idx;
    int tickCnt;
    logic prev;
    idx = 0;
    tickCnt = 0;
    prev = sclkOut;
    while (idx < nRec) begin
      @(negedge clk);
      if (sclkOut != prev) begin
        if (sclkOut == onRise) begin
          recSdo[idx] = sdo;
          recWs[idx] = wsOut;
          idx++;
        end
        prev = sclkOut;
      end
      bitTick = (tickCnt == 3);
      tickCnt = (tickCnt + 1) % 4;
    end
    @(negedge clk);
    bitTick = 1'b0;
  endtask

  task automatic checkFrame(input int slot, input int off, input int nWords, input string req);
    int j0;
    logic anyPre;
    j0 = -1;
    anyPre = 1'b0;
    for (int j = 1; j < 512; j++)
      if (j0 < 0 && recWs[j-1] == 1'b1 && recWs[j] == 1'b0) j0 = j;
    check(j0 > 0, "R2 left frame start seen", 32'(j0), 32'd1);
    if (j0 > 0) begin
      for (int j = 0; j < j0 + off; j++) anyPre = anyPre | recSdo[j];
      check(anyPre == 1'b0, "R14 zeros before first left slot", {31'd0, anyPre}, 32'd0);
      for (int k = 0; k < nWords; k++) begin
        logic [31:0] got;
        got = '0;
        for (int i = 0; i < slot; i++) got[31-i] = recSdo[j0 + off + k*slot + i];
        check(got == expW[k], req, got, expW[k]);
      end
    end
  endtask

  task automatic cycleEnable();
    @(negedge clk);
    globalEn = 1'b0;
    idle(3);
    globalEn = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    intMask = 3'b111;
    idle(2);
    // R12: reset state, global enable off
    check(sdo == 1'b0, "R12 reset sdo", {31'd0, sdo}, 32'd0);
    check(sclkOut == 1'b0 && wsOut == 1'b0, "R12 reset timing outputs", {30'd0, sclkOut, wsOut}, 32'd0);
    check(irq == 1'b0 && overrun == 1'b0 && underrun == 1'b0, "R12 reset flags",
          {29'd0, irq, overrun, underrun}, 32'd0);

    // vector walk: R1 R2 R3 R4 R5 R10 R9 per slot length
    for (int g = 0; g < 3; g++) begin
      int slot;
      @(negedge clk);
      globalEn = 1'b0;
      slotSel = VEC[g*4].sel;
      launchOnRise = 1'b0;
      txEn = 1'b1;
      idle(3);
      globalEn = 1'b1;
      slot = (slotSel == 2'd0) ? 16 : (slotSel == 2'd1) ? 24 : 32;
      for (int v = 0; v < 4; v++) begin
        writeWord(VEC[g*4 + v].smp);
        expW[v] = VEC[g*4 + v].exp;
      end
      expW[4] = '0;
      expW[5] = '0;
      stream(slot + 3 + 6*slot, 1'b1);
      check(recWs[0] == 1'b0 && recWs[1] == 1'b1 && recWs[slot] == 1'b1 &&
            recWs[slot+1] == 1'b0 && recWs[2*slot] == 1'b0 && recWs[2*slot+1] == 1'b1,
            "R3 word select period", 32'(slot), 32'(slot));
      checkFrame(slot, 1, 6, (slot == 16) ? "R5 truncated words" :
                             (slot == 32) ? "R4 padded words" : "R1 exact words");
      check(underrun == 1'b1, "R10 underrun after queue drained", {31'd0, underrun}, 32'd1);
      pulseRead();
      check(underrun == 1'b0, "R9 underrun cleared by read", {31'd0, underrun}, 32'd0);
    end

    // threshold, overrun, masking, transmitter disable
    @(negedge clk);
    globalEn = 1'b0;
    txEn = 1'b0;
    idle(3);
    globalEn = 1'b1;
    intMask = 3'b001;
    trigLevel = 5'd2;
    idle(1);
    check(irq == 1'b1, "R8 empty queue at or below mark", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 3; i++) writeWord(24'hFFFFFF);
    idle(1);
    check(irq == 1'b0, "R8 level 3 above mark 2", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 13; i++) writeWord(24'hFFFFFF);
    intMask = 3'b010;
    idle(1);
    check(overrun == 1'b0 && irq == 1'b0, "R7 sixteen writes fit", {30'd0, overrun, irq}, 32'd0);
    writeWord(24'h000000);
    idle(1);
    check(overrun == 1'b1, "R7 write into full queue", {31'd0, overrun}, 32'd1);
    check(irq == 1'b1, "R11 overrun unmasked", {31'd0, irq}, 32'd1);
    intMask = 3'b000;
    idle(1);
    check(irq == 1'b0, "R11 all masked", {31'd0, irq}, 32'd0);
    intMask = 3'b001;
    trigLevel = 5'd16;
    idle(1);
    check(irq == 1'b1, "R8 full level equals mark", {31'd0, irq}, 32'd1);
    trigLevel = 5'd15;
    stream(80, 1'b1);
    begin
      logic anyOne;
      anyOne = 1'b0;
      for (int j = 0; j < 80; j++) anyOne = anyOne | recSdo[j];
      check(anyOne == 1'b0, "R13 sdo low with transmitter off", {31'd0, anyOne}, 32'd0);
    end
    check(irq == 1'b0, "R13 nothing consumed with transmitter off", {31'd0, irq}, 32'd0);
    check(overrun == 1'b1, "R9 overrun sticky", {31'd0, overrun}, 32'd1);
    pulseRead();
    check(overrun == 1'b0, "R9 overrun cleared by read", {31'd0, overrun}, 32'd0);

    // global disable: flush, ignored writes, lost word
    @(negedge clk);
    globalEn = 1'b0;
    idle(2);
    check(sclkOut == 1'b0 && wsOut == 1'b0, "R12 timing low while disabled", {30'd0, sclkOut, wsOut}, 32'd0);
    for (int i = 0; i < 3; i++) writeWord(24'h777777);
    @(negedge clk);
    globalEn = 1'b1;
    trigLevel = 5'd0;
    idle(1);
    check(irq == 1'b1, "R12 queue flushed and writes ignored", {31'd0, irq}, 32'd1);
    slotSel = 2'd0;
    txEn = 1'b1;
    for (int i = 0; i < 4; i++) writeWord(24'hFFFFFF);
    stream(23, 1'b1);
    check(recSdo[22] == 1'b1, "R1 word in flight", {31'd0, recSdo[22]}, 32'd1);
    @(negedge clk);
    globalEn = 1'b0;
    idle(2);
    check(sdo == 1'b0, "R12 sdo low after disable", {31'd0, sdo}, 32'd0);
    pulseRead();
    cycleEnable();
    for (int k = 0; k < 3; k++) expW[k] = '0;
    stream(16 + 3 + 3*16, 1'b1);
    checkFrame(16, 1, 3, "R12 flushed words not sent");
    check(underrun == 1'b1, "R10 underrun on flushed queue", {31'd0, underrun}, 32'd1);
    pulseRead();

    // launch on rising edge, sampled on falling edges
    @(negedge clk);
    globalEn = 1'b0;
    launchOnRise = 1'b1;
    slotSel = 2'd0;
    idle(3);
    globalEn = 1'b1;
    writeWord(24'h9ABCDE);
    writeWord(24'h0F0F0F);
    expW[0] = 32'h9ABC0000;
    expW[1] = 32'h0F0F0000;
    stream(60, 1'b0);
    checkFrame(16, 2, 2, "R6 rising-edge launch");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule